// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block computes sums of products such as filter taps or correlation lags, and accepts one new coefficient-sample pair on every clock cycle. Each pair of signed two's-complement operands is multiplied, and the full-width product is held in a product register. In the next stage the product is added to, or subtracted from, an accumulator. The accumulator keeps the whole double-precision product and also has guard bits above it, so that long sums do not wrap.

A term that carries the clear control starts a new sum: the accumulator's old contents are replaced by zero before that term is applied. The term flagged as last closes the sum. An output stage then turns the accumulator into one result word. It applies an arithmetic right shift, an optional round-half-up and saturation. The shift and round settings are taken from the last term, so each sum can pick its own output format. In fractional mode each product is doubled before it is accumulated. With that mode and a shift equal to the operand width, Q15 inputs give a Q15 result.

Top module: `dsp_mac`

## Requirements
- R1: With fractional mode off and shift 0, the result equals the sum of opA*opB over the terms of a sum, where both operands are signed two's complement.
- R2: A term with subMode high subtracts its product from the running sum instead of adding it.
- R3: A valid term with clrAcc high replaces the running sum with zero before its own product is applied. It also clears the overflow flag.
- R4: Terms may arrive on consecutive cycles or with idle cycles between them. In a cycle with inValid low, opA, opB, clrAcc and lastTerm have no effect on the sum and produce no result.
- R5: resultValid is high for one cycle exactly three clock edges after the edge that samples a valid term with lastTerm high. result changes only in that cycle and holds its value otherwise.
- R6: With fracMode high on a term, that term's product is doubled before it is accumulated.
- R7: The result is the sum arithmetically shifted right by shiftSel bits, rounded toward minus infinity. shiftSel and roundSel are taken from the last term of the sum.
- R8: With roundSel high and shiftSel nonzero, 2^(shiftSel-1) is added before the shift, which rounds halves toward plus infinity. With shiftSel 0, roundSel has no effect.
- R9: A scaled value above 32767 gives 32767 and a value below -32768 gives -32768. Either case sets overflow, which then stays high through later results until a clear.
- R10: Intermediate sums up to 2^39 in magnitude are kept without wrapping. Four products of -32768*-32768 give 2^32, and with shift 31 this reads out as 2.
- R11: After reset, result is 0 and resultValid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and controls of this cycle form a term |
| opA | input | 16 | Signed operand (coefficient) |
| opB | input | 16 | Signed operand (sample) |
| clrAcc | input | 1 | Term starts a new sum |
| subMode | input | 1 | Subtract this term's product |
| fracMode | input | 1 | Double this term's product (fractional format) |
| lastTerm | input | 1 | Term closes the sum and requests a result |
| roundSel | input | 1 | Round half up at the output (taken from the last term) |
| shiftSel | input | 5 | Output right-shift amount (taken from the last term) |
| result | output | 16 | Scaled, rounded and saturated result word |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | Sticky saturation flag, cleared by a clearing term |

## Verification
The main function is exercised with mixed-sign products, with an add/subtract mix, with idle cycles that carry junk operands and controls, and with single-term sums closed on consecutive cycles. Together these separate a correct running sum from one that drops terms, mishandles sign, or reacts to invalid cycles. Positive and negative values are shifted with and without rounding, including exact halves, and these cases show apart truncation, toward-zero rounding and round-half-up. Saturation runs in both directions, followed by a non-clearing sum and then a clearing one, to check that the flag is sticky. A run of four maximal products read out with a large shift shows whether the guard bits are present.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

  // strobes issued by the control pipeline to the datapath
  typedef struct packed {
    logic prodEn;    // load product register this cycle
    logic accEn;     // a term reaches the accumulator
    logic accClr;    // accumulator input forced to zero
    logic accSub;    // subtract instead of add
    logic accFrac;   // double the product (fractional format)
    logic outEn;     // load the result word
    logic outRound;  // round half up in the output stage
  } macStrobes_t;

endpackage

// File: rtl/dsp_mac_ctrl.sv
module dsp_mac_ctrl
  import dsp_mac_pkg::*;
#(
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            clrAcc,
  input  logic            subMode,
  input  logic            fracMode,
  input  logic            lastTerm,
  input  logic            roundSel,
  input  logic [SH_W-1:0] shiftSel,
  output macStrobes_t     stb,
  output logic [SH_W-1:0] outShift,
  output logic            resultValid
);

  // stage 1: term controls aligned with the product register
  logic            v1, clr1, sub1, frac1, last1, rnd1;
  logic [SH_W-1:0] sh1;
  // stage 2: closing controls aligned with the accumulator
  logic            last2, rnd2;
  logic [SH_W-1:0] sh2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1    <= 1'b0;
      clr1  <= 1'b0;
      sub1  <= 1'b0;
      frac1 <= 1'b0;
      last1 <= 1'b0;
      rnd1  <= 1'b0;
      sh1   <= '0;
    end else begin
      v1    <= inValid;
      clr1  <= inValid & clrAcc;
      sub1  <= subMode;
      frac1 <= fracMode;
      last1 <= inValid & lastTerm;
      if (inValid & lastTerm) begin
        rnd1 <= roundSel;
        sh1  <= shiftSel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      last2       <= 1'b0;
      rnd2        <= 1'b0;
      sh2         <= '0;
      resultValid <= 1'b0;
    end else begin
      last2       <= last1;
      resultValid <= last2;
      if (last1) begin
        rnd2 <= rnd1;
        sh2  <= sh1;
      end
    end
  end

  always_comb begin
    stb.prodEn   = inValid;
    stb.accEn    = v1;
    stb.accClr   = clr1;
    stb.accSub   = sub1;
    stb.accFrac  = frac1;
    stb.outEn    = last2;
    stb.outRound = rnd2;
    outShift     = sh2;
  end

endmodule

// File: rtl/dsp_mac_outstage.sv
module dsp_mac_outstage #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [ACC_W-1:0] accIn,
  input  logic                    outEn,
  input  logic                    outRound,
  input  logic [SH_W-1:0]         outShift,
  input  logic                    clrOvf,
  output logic signed [OUT_W-1:0] result,
  output logic                    overflow
);

  localparam int EXT_W = ACC_W + 1;
  localparam logic [OUT_W-1:0] MAX_WORD = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_WORD = {1'b1, {(OUT_W-1){1'b0}}};
  localparam int TOP_W = EXT_W - OUT_W + 1;

  logic signed [EXT_W-1:0] roundInc, biased, shifted;
  logic [TOP_W-1:0]        topBits;
  logic                    fits;
  logic [OUT_W-1:0]        satWord;

  always_comb begin
    roundInc = '0;
    if (outRound && (outShift != '0))
      roundInc = {{(EXT_W-1){1'b0}}, 1'b1} << (outShift - SH_W'(1));
    biased  = {accIn[ACC_W-1], accIn} + roundInc;
    shifted = biased >>> outShift;
    topBits = shifted[EXT_W-1:OUT_W-1];
    fits    = (topBits == '0) || (topBits == '1);
    if (fits)                  satWord = shifted[OUT_W-1:0];
    else if (shifted[EXT_W-1]) satWord = MIN_WORD;
    else                       satWord = MAX_WORD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      overflow <= 1'b0;
    end else begin
      if (outEn) result <= satWord;
      overflow <= (overflow & ~clrOvf) | (outEn & ~fits);
    end
  end

endmodule

// File: rtl/dsp_mac_datapath.sv
module dsp_mac_datapath
  import dsp_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int GUARD = 8,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  macStrobes_t             stb,
  input  logic [SH_W-1:0]         outShift,
  input  logic signed [OP_W-1:0]  opA,
  input  logic signed [OP_W-1:0]  opB,
  output logic signed [OUT_W-1:0] result,
  output logic                    overflow
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + GUARD;

  logic signed [PROD_W-1:0] prodQ;
  logic signed [ACC_W-1:0]  accQ, addend, accBase, accNext;

  // multiply stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prodQ <= '0;
    else if (stb.prodEn) prodQ <= PROD_W'(opA) * PROD_W'(opB);
  end

  // accumulate stage
  always_comb begin
    addend = ACC_W'(prodQ);
    if (stb.accFrac) addend = addend <<< 1;
    accBase = stb.accClr ? '0 : accQ;
    accNext = stb.accSub ? (accBase - addend) : (accBase + addend);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          accQ <= '0;
    else if (stb.accEn) accQ <= accNext;
  end

  dsp_mac_outstage #(
    .ACC_W(ACC_W),
    .OUT_W(OUT_W),
    .SH_W (SH_W)
  ) u_out (
    .clk     (clk),
    .rstN    (rstN),
    .accIn   (accQ),
    .outEn   (stb.outEn),
    .outRound(stb.outRound),
    .outShift(outShift),
    .clrOvf  (stb.accEn & stb.accClr),
    .result  (result),
    .overflow(overflow)
  );

endmodule

// File: rtl/dsp_mac.sv
module dsp_mac
  import dsp_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int GUARD = 8,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [OP_W-1:0]  opA,
  input  logic signed [OP_W-1:0]  opB,
  input  logic                    clrAcc,
  input  logic                    subMode,
  input  logic                    fracMode,
  input  logic                    lastTerm,
  input  logic                    roundSel,
  input  logic [SH_W-1:0]         shiftSel,
  output logic signed [OUT_W-1:0] result,
  output logic                    resultValid,
  output logic                    overflow
);

  macStrobes_t     stb;
  logic [SH_W-1:0] outShift;

  dsp_mac_ctrl #(.SH_W(SH_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .clrAcc     (clrAcc),
    .subMode    (subMode),
    .fracMode   (fracMode),
    .lastTerm   (lastTerm),
    .roundSel   (roundSel),
    .shiftSel   (shiftSel),
    .stb        (stb),
    .outShift   (outShift),
    .resultValid(resultValid)
  );

  dsp_mac_datapath #(
    .OP_W (OP_W),
    .GUARD(GUARD),
    .OUT_W(OUT_W),
    .SH_W (SH_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .outShift(outShift),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .overflow(overflow)
  );

endmodule

// File: rtl/dsp_mac_checker.sv
module dsp_mac_checker #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             lastTerm,
  input logic             clrAcc,
  input logic             resultValid,
  input logic             overflow,
  input logic [OUT_W-1:0] result
);

  localparam logic [OUT_W-1:0] MAX_WORD = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_WORD = {1'b1, {(OUT_W-1){1'b0}}};

  p_result_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(inValid && lastTerm, 3));

  p_last_yields_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lastTerm) |=> ##2 resultValid);

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> resultValid);

  p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $past(inValid && clrAcc, 2));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> (resultValid && (result == MAX_WORD || result == MIN_WORD)));

endmodule

bind dsp_mac dsp_mac_checker #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .lastTerm   (lastTerm),
  .clrAcc     (clrAcc),
  .resultValid(resultValid),
  .overflow   (overflow),
  .result     (result)
);

// File: tb/dsp_mac_bench.sv
`timescale 1ns/1ps
module dsp_mac_bench;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [15:0] opA = '0, opB = '0;
  logic               clrAcc = 1'b0, subMode = 1'b0, fracMode = 1'b0;
  logic               lastTerm = 1'b0, roundSel = 1'b0;
  logic [4:0]         shiftSel = '0;
  logic signed [15:0] result;
  logic               resultValid, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsp_mac u_dsp_mac (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .clrAcc(clrAcc), .subMode(subMode), .fracMode(fracMode),
    .lastTerm(lastTerm), .roundSel(roundSel), .shiftSel(shiftSel),
    .result(result), .resultValid(resultValid), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic term(input int a, input int b, input bit clr, input bit sub,
                      input bit frac, input bit last, input bit rnd, input int sh);
    @(negedge clk);
    inValid  = 1'b1;
    opA      = 16'(a);
    opB      = 16'(b);
    clrAcc   = clr;
    subMode  = sub;
    fracMode = frac;
    lastTerm = last;
    roundSel = rnd;
    shiftSel = 5'(sh);
  endtask

  // invalid cycle carrying junk operands and controls
  task automatic junk();
    @(negedge clk);
    inValid = 1'b0; opA = 16'sd999; opB = -16'sd77;
    clrAcc = 1'b1; lastTerm = 1'b1; subMode = 1'b1;
    chk("R4 no result on invalid cycle", int'(resultValid), 0);
  endtask

  task automatic collect(input string req, input int exp, input bit expOvf);
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " valid low +1"}, int'(resultValid), 0);
    @(negedge clk);
    chk({req, " valid low +2"}, int'(resultValid), 0);
    @(negedge clk);
    chk({req, " valid at +3"}, int'(resultValid), 1);
    chk({req, " result"}, int'(result), exp);
    chk({req, " overflow"}, int'(overflow), int'(expOvf));
  endtask

  task automatic t_reset();
    chk("R11 reset result", int'(result), 0);
    chk("R11 reset valid", int'(resultValid), 0);
    chk("R11 reset overflow", int'(overflow), 0);
  endtask

  task automatic t_basic();
    term(3, 4, 1, 0, 0, 0, 0, 0);
    term(-5, 6, 0, 0, 0, 0, 0, 0);
    term(7, -8, 0, 0, 0, 1, 0, 0);
    collect("R1 mixed-sign sum", -74, 0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      opA = 16'(i * 1234); opB = 16'sd321;
      chk("R5 result holds", int'(result), -74);
      chk("R5 valid one cycle", int'(resultValid), 0);
    end
  endtask

  task automatic t_sub();
    term(100, 100, 1, 0, 0, 0, 0, 0);
    term(30, 50, 0, 1, 0, 1, 0, 0);
    collect("R2 subtract", 8500, 0);
  endtask

  task automatic t_gaps();
    term(2, 3, 1, 0, 0, 0, 0, 0);
    junk();
    junk();
    term(4, 5, 0, 0, 0, 1, 0, 0);
    collect("R4 gaps ignored", 26, 0);
  endtask

  task automatic t_back2back();
    term(2, 2, 1, 0, 0, 1, 0, 0);
    term(3, 3, 1, 0, 0, 1, 0, 0);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk("R4 first of pair valid", int'(resultValid), 1);
    chk("R4 first of pair", int'(result), 4);
    @(negedge clk);
    chk("R4 second of pair valid", int'(resultValid), 1);
    chk("R4 second of pair", int'(result), 9);
  endtask

  task automatic t_frac();
    term(16384, 16384, 1, 0, 1, 1, 0, 16);
    collect("R6 fractional 0.5*0.5", 8192, 0);
  endtask

  task automatic t_shift();
    term(1000, 1000, 1, 0, 0, 1, 0, 8);
    collect("R7 positive shift", 3906, 0);
    term(-1000, 1000, 1, 0, 0, 1, 0, 8);
    collect("R7 negative shift floors", -3907, 0);
  endtask

  task automatic t_round();
    term(3, 128, 1, 0, 0, 1, 1, 8);
    collect("R8 round half up positive", 2, 0);
    term(-3, 128, 1, 0, 0, 1, 1, 8);
    collect("R8 round half up negative", -1, 0);
    term(7, 1, 1, 0, 0, 1, 1, 0);
    collect("R8 round with shift 0", 7, 0);
  endtask

  task automatic t_sat();
    term(200, 200, 1, 0, 0, 1, 0, 0);
    collect("R9 saturate high", 32767, 1);
    term(200, 200, 0, 1, 0, 1, 0, 0);
    collect("R9 sticky flag", 0, 1);
    term(-200, 200, 1, 0, 0, 1, 0, 0);
    collect("R9 saturate low", -32768, 1);
    term(1, 1, 1, 0, 0, 1, 0, 0);
    collect("R3 clear drops flag", 1, 0);
  endtask

  task automatic t_guard();
    term(-32768, -32768, 1, 0, 0, 0, 0, 0);
    term(-32768, -32768, 0, 0, 0, 0, 0, 0);
    term(-32768, -32768, 0, 0, 0, 0, 0, 0);
    term(-32768, -32768, 0, 0, 0, 1, 0, 31);
    collect("R10 guard bits", 2, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_sub();
    t_gaps();
    t_back2back();
    t_frac();
    t_shift();
    t_round();
    t_sat();
    t_guard();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule